// File: doc/BRIEF.md
# Fuse Row Key Assembler

This block builds a cryptographic key out of a run of consecutive fuse rows. A one-cycle start pulse supplies a first row, a last row and a key length counted in 32-bit words. The block then reads rows one at a time over a request/response link. Each clean row adds one word to an internal key buffer. A row whose response is flagged with an ECC error or failure bits adds nothing, and the walk moves on to the next row.

Fetching stops when the requested number of words has been collected or when the row index moves past the last row. A pulse on `done` then reports the verdict. The verdict is built from a bitwise OR and a bitwise AND of every word that was accepted. A key that is all zeros, a key that is all ones, or a walk that ran beyond the last row is rejected. Once the run is over, the collected words can be read back through a synchronous read port on the key buffer.

Top module: `key_row_fetch`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req` are low.
- R2: A `start` pulse while `busy` is low begins a fetch: `busy` rises on the next cycle and the first `rd_req` carries `start_row`. A `start` pulse while `busy` is high has no effect on the rows requested.
- R3: At most one read is outstanding. `rd_req` is a one-cycle pulse, and the next one comes only after `rsp_valid` has answered the previous one. A `rsp_valid` with no read outstanding is ignored.
- R4: Requested rows begin at `start_row` and rise by exactly one per read. No row above `end_row` is requested. The walk stops once the key holds the requested number of words or the row index exceeds `end_row`.
- R5: A response with `rsp_ecc_err` or `rsp_fail_bits` high contributes no key word, and the next request still moves to the following row.
- R6: Each clean response stores `rsp_data` as the next key word, in ascending index order starting at 0. `key_rd_data` returns the word at `key_rd_idx` one cycle after the index is applied.
- R7: The verdict is fail when the AND of all accepted words equals all ones.
- R8: The verdict is fail when the OR of all accepted words equals zero.
- R9: The verdict is fail when the row index has passed `end_row` at the finish. This includes a key that fills on `end_row` itself and a `start_row` above `end_row`, in which case no read is issued.
- R10: A `key_len` of zero finishes with no reads and a fail verdict. A `key_len` above `MAX_WORDS` is treated as `MAX_WORDS`.
- R11: `done` is a one-cycle pulse. `busy` is low in the cycle `done` is high. `pass` is valid with `done` and holds until the next finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a fetch |
| start_row | input | ROW_W | First row to read |
| end_row | input | ROW_W | Last row that may be read |
| key_len | input | LEN_W | Number of key words wanted |
| busy | output | 1 | High while a fetch runs |
| done | output | 1 | One-cycle finish pulse |
| pass | output | 1 | Verdict of the last fetch (1 = good key) |
| rd_req | output | 1 | One-cycle row read request |
| rd_row | output | ROW_W | Row index of the request |
| rsp_valid | input | 1 | Response to the outstanding read |
| rsp_data | input | WORD_W | Row data word |
| rsp_ecc_err | input | 1 | Row reported an ECC error |
| rsp_fail_bits | input | 1 | Row reported failure bits |
| key_rd_idx | input | IDX_W | Key buffer read index |
| key_rd_data | output | WORD_W | Key word, one cycle after the index |

## Verification
A wrong word counter or row counter shows up immediately in the sequence of `rd_row` values and in the number of requests. It also shows up at `done`, which then arrives early or late. A corrupt OR or AND accumulator stays hidden until the finish, where it flips `pass` for keys that are all zero, all one or mixed. A bad write index is exposed only when the buffer is read back, in the cycle after `key_rd_idx` is applied. The bench therefore sweeps row windows, lengths, error-row patterns, data classes and response latencies, and it checks all three of these observation points on every run.

// File: rtl/kf_pkg.sv
package kf_pkg;
  typedef enum logic [1:0] {
    KF_IDLE  = 2'd0,
    KF_CHECK = 2'd1,
    KF_WAIT  = 2'd2
  } kf_state_e;
endpackage

// File: rtl/kf_ctrl.sv
module kf_ctrl #(
  parameter int ROW_W     = 10,
  parameter int MAX_WORDS = 8,
  parameter int LEN_W     = 4,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ROW_W-1:0] start_row,
  input  logic [ROW_W-1:0] end_row,
  input  logic [LEN_W-1:0] key_len,
  input  logic             rsp_valid,
  input  logic             rsp_flagged,
  output logic             busy,
  output logic             rd_req,
  output logic [ROW_W-1:0] rd_row,
  output logic             acc_clr,
  output logic             acc_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             fin_evt,
  output logic             past_end
);
  import kf_pkg::*;

  kf_state_e        state_q;
  logic [ROW_W:0]   row_q;
  logic [ROW_W:0]   end_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             req_q;
  logic [ROW_W-1:0] rdrow_q;
  logic [31:0]      len_ext;
  logic [CNT_W-1:0] len_clamped;
  logic             key_full;
  logic             launch;

  assign len_ext     = 32'(key_len);
  assign len_clamped = (len_ext > 32'(MAX_WORDS)) ? CNT_W'(MAX_WORDS) : CNT_W'(len_ext);
  assign launch      = (state_q == KF_IDLE) && start;
  assign key_full    = (cnt_q == len_q);
  assign past_end    = (row_q > end_q);
  assign fin_evt     = (state_q == KF_CHECK) && (key_full || past_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KF_IDLE;
      row_q   <= '0;
      end_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      rdrow_q <= '0;
    end else begin
      req_q <= 1'b0;
      unique case (state_q)
        KF_IDLE: begin
          if (start) begin
            row_q   <= {1'b0, start_row};
            end_q   <= {1'b0, end_row};
            len_q   <= len_clamped;
            cnt_q   <= '0;
            busy_q  <= 1'b1;
            state_q <= KF_CHECK;
          end
        end
        KF_CHECK: begin
          if (key_full || past_end) begin
            busy_q  <= 1'b0;
            state_q <= KF_IDLE;
          end else begin
            req_q   <= 1'b1;
            rdrow_q <= row_q[ROW_W-1:0];
            state_q <= KF_WAIT;
          end
        end
        KF_WAIT: begin
          if (rsp_valid) begin
            row_q <= row_q + 1'b1;
            if (!rsp_flagged) begin
              cnt_q <= cnt_q + 1'b1;
            end
            state_q <= KF_CHECK;
          end
        end
        default: state_q <= KF_IDLE;
      endcase
    end
  end

  assign busy    = busy_q;
  assign rd_req  = req_q;
  assign rd_row  = rdrow_q;
  assign acc_clr = launch;
  assign acc_en  = (state_q == KF_WAIT) && rsp_valid && !rsp_flagged;
  assign wr_idx  = cnt_q[IDX_W-1:0];
endmodule

// File: rtl/kf_accum.sv
module kf_accum #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  input  logic              fin_evt,
  input  logic              past_end,
  output logic              done,
  output logic              pass
);
  localparam logic [WORD_W-1:0] ONES = {WORD_W{1'b1}};

  logic [WORD_W-1:0] or_q;
  logic [WORD_W-1:0] and_q;
  logic              done_q;
  logic              pass_q;
  logic              reject;

  assign reject = (and_q == ONES) || (or_q == '0) || past_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      or_q   <= '0;
      and_q  <= ONES;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= fin_evt;
      if (clr) begin
        or_q  <= '0;
        and_q <= ONES;
      end else if (en) begin
        or_q  <= or_q | word;
        and_q <= and_q & word;
      end
      if (fin_evt) begin
        pass_q <= !reject;
      end
    end
  end

  assign done = done_q;
  assign pass = pass_q;
endmodule

// File: rtl/kf_keybuf.sv
module kf_keybuf #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/key_row_fetch.sv
module key_row_fetch #(
  parameter int ROW_W     = 10,
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 8,
  parameter int LEN_W     = 4,
  localparam int IDX_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ROW_W-1:0]  start_row,
  input  logic [ROW_W-1:0]  end_row,
  input  logic [LEN_W-1:0]  key_len,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              rd_req,
  output logic [ROW_W-1:0]  rd_row,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic              rsp_ecc_err,
  input  logic              rsp_fail_bits,
  input  logic [IDX_W-1:0]  key_rd_idx,
  output logic [WORD_W-1:0] key_rd_data
);
  logic             flagged;
  logic             acc_clr;
  logic             acc_en;
  logic [IDX_W-1:0] wr_idx;
  logic             fin_evt;
  logic             past_end;

  assign flagged = rsp_ecc_err | rsp_fail_bits;

  kf_ctrl #(
    .ROW_W(ROW_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_row(start_row),
    .end_row(end_row), .key_len(key_len), .rsp_valid(rsp_valid),
    .rsp_flagged(flagged), .busy(busy), .rd_req(rd_req), .rd_row(rd_row),
    .acc_clr(acc_clr), .acc_en(acc_en), .wr_idx(wr_idx),
    .fin_evt(fin_evt), .past_end(past_end)
  );

  kf_accum #(.WORD_W(WORD_W)) u_accum (
    .clk(clk), .rst(rst), .clr(acc_clr), .en(acc_en), .word(rsp_data),
    .fin_evt(fin_evt), .past_end(past_end), .done(done), .pass(pass)
  );

  kf_keybuf #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .we(acc_en), .waddr(wr_idx), .wdata(rsp_data),
    .raddr(key_rd_idx), .rdata(key_rd_data)
  );
endmodule

// File: rtl/kf_chk.sv
module kf_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [ROW_W-1:0] start_row,
  input logic [ROW_W-1:0] end_row,
  input logic             busy,
  input logic             done,
  input logic             rd_req,
  input logic [ROW_W-1:0] rd_row,
  input logic             rsp_valid
);
  logic             pend_q;
  logic [ROW_W-1:0] first_q;
  logic [ROW_W-1:0] last_q;
  logic [ROW_W-1:0] prev_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
      prev_q  <= '0;
      seen_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q | rd_req) & ~rsp_valid;
      if (start && !busy) begin
        first_q <= start_row;
        last_q  <= end_row;
        seen_q  <= 1'b0;
      end else if (rd_req) begin
        prev_q <= rd_row;
        seen_q <= 1'b1;
      end
    end
  end

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !pend_q);
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R4
  row_window_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_row >= first_q && rd_row <= last_q));
  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && seen_q) |-> (rd_row == prev_q + 1'b1));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind key_row_fetch kf_chk #(.ROW_W(ROW_W)) u_kf_chk (
  .clk(clk), .rst(rst), .start(start), .start_row(start_row),
  .end_row(end_row), .busy(busy), .done(done), .rd_req(rd_req),
  .rd_row(rd_row), .rsp_valid(rsp_valid)
);

// File: tb/key_row_fetch_tb.sv
module key_row_fetch_tb;
  localparam int ROW_W = 10, WORD_W = 32, MAX_WORDS = 8, LEN_W = 4, IDX_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ROW_W-1:0]  start_row = '0;
  logic [ROW_W-1:0]  end_row = '0;
  logic [LEN_W-1:0]  key_len = '0;
  logic              busy, done, pass, rd_req;
  logic [ROW_W-1:0]  rd_row;
  logic              rsp_valid = 1'b0;
  logic [WORD_W-1:0] rsp_data = '0;
  logic              rsp_ecc_err = 1'b0;
  logic              rsp_fail_bits = 1'b0;
  logic [IDX_W-1:0]  key_rd_idx = '0;
  logic [WORD_W-1:0] key_rd_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  key_row_fetch #(.ROW_W(ROW_W), .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_row(start_row), .end_row(end_row),
    .key_len(key_len), .busy(busy), .done(done), .pass(pass), .rd_req(rd_req),
    .rd_row(rd_row), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ecc_err(rsp_ecc_err), .rsp_fail_bits(rsp_fail_bits),
    .key_rd_idx(key_rd_idx), .key_rd_data(key_rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] row_data(input int r, input int kind);
    case (kind)
      0:       return (32'(r) * 32'h9E3779B1) ^ 32'h5A5A0001;
      1:       return 32'hFFFFFFFF;
      2:       return 32'h0;
      default: return r[0] ? 32'hFFFFFFFF : 32'h0;
    endcase
  endfunction

  function automatic bit row_bad(input int r, input int pat);
    case (pat)
      0:       return 1'b0;
      1:       return (r % 3) == 1;
      default: return (r % 2) == 0;
    endcase
  endfunction

  task automatic run_fetch(input int s, input int e, input int len, input int kind,
                           input int pat, input int lat, input bit poke);
    logic [31:0] ew [MAX_WORDS];
    logic [31:0] or_m = 32'h0;
    logic [31:0] and_m = 32'hFFFFFFFF;
    int n = 0;
    int r = s;
    int reads = 0;
    int lim = (len > MAX_WORDS) ? MAX_WORDS : len;
    bit exp_pass;
    string tag;
    int idx = 0;
    int waitl = 0;
    bit waiting = 1'b0;
    int pend_row = 0;
    bit got_done = 1'b0;
    bit seq_ok = 1'b1;
    logic got_pass = 1'b0;
    logic got_busy = 1'b0;
    int guard = 0;

    while (n < lim && r <= e) begin
      if (!row_bad(r, pat)) begin
        ew[n] = row_data(r, kind);
        or_m  = or_m | ew[n];
        and_m = and_m & ew[n];
        n++;
      end
      r++;
      reads++;
    end
    exp_pass = !((and_m == 32'hFFFFFFFF) || (or_m == 32'h0) || (r > e));
    if (lim == 0) tag = "R10";
    else if (r > e) tag = "R9";
    else if (and_m == 32'hFFFFFFFF) tag = "R7";
    else if (or_m == 32'h0) tag = "R8";
    else tag = "R4";

    start     = 1'b1;
    start_row = ROW_W'(s);
    end_row   = ROW_W'(e);
    key_len   = LEN_W'(len);
    while (guard < 400) begin
      @(negedge clk);
      guard++;
      start = 1'b0;
      if (rsp_valid) begin
        rsp_valid     = 1'b0;
        rsp_ecc_err   = 1'b0;
        rsp_fail_bits = 1'b0;
      end
      if (done) begin
        got_done = 1'b1;
        got_pass = pass;
        got_busy = busy;
        break;
      end
      if (rd_req) begin
        if (idx == 0) chk(busy == 1'b1, "R2", "busy during fetch", 32'(busy), 32'h1);
        if (int'(rd_row) != s + idx) seq_ok = 1'b0;
        idx++;
        waiting  = 1'b1;
        waitl    = lat;
        pend_row = int'(rd_row);
        if (poke && idx == 1) begin
          start     = 1'b1;
          start_row = ROW_W'(9);
          end_row   = ROW_W'(12);
          key_len   = LEN_W'(1);
        end
      end
      if (waiting) begin
        if (waitl == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = row_data(pend_row, kind);
          if (row_bad(pend_row, pat)) begin
            rsp_ecc_err   = (pend_row % 4) < 2;
            rsp_fail_bits = (pend_row % 4) >= 2;
          end
          waiting = 1'b0;
        end else begin
          waitl--;
        end
      end
    end

    chk(got_done, "R11", "done seen", 32'(got_done), 32'h1);
    chk(got_busy == 1'b0, "R11", "busy low with done", 32'(got_busy), 32'h0);
    chk(got_pass == exp_pass, tag, "verdict", 32'(got_pass), 32'(exp_pass));
    chk(idx == reads, (len > MAX_WORDS) ? "R10" : (pat != 0 ? "R5" : "R4"),
        "read count", 32'(idx), 32'(reads));
    chk(seq_ok, "R4", "row sequence", 32'(seq_ok), 32'h1);
    for (int i = 0; i < n; i++) begin
      key_rd_idx = IDX_W'(i);
      @(negedge clk);
      chk(key_rd_data == ew[i], "R6", "key word", key_rd_data, ew[i]);
    end
    @(negedge clk);
    chk(pass == exp_pass, "R11", "verdict held", 32'(pass), 32'(exp_pass));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles >= 190000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'h0);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'h0);
    chk(rd_req == 1'b0, "R1", "rd_req after reset", 32'(rd_req), 32'h0);

    // R3 stray response while idle
    rsp_valid = 1'b1;
    rsp_data  = 32'hFFFFFFFF;
    @(negedge clk);
    rsp_valid = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && rd_req == 1'b0, "R3", "stray response ignored",
        {29'h0, busy, done, rd_req}, 32'h0);
    run_fetch(2, 9, 3, 0, 0, 1, 1'b0);

    // R2 start while busy ignored
    run_fetch(2, 6, 2, 0, 0, 2, 1'b1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2", "no second fetch", 32'(busy), 32'h0);

    // R9 key fills exactly on the last row
    run_fetch(3, 4, 2, 0, 0, 0, 1'b0);

    for (int si = 0; si < 2; si++) begin
      for (int ei = 0; ei < 5; ei++) begin
        for (int li = 0; li < 7; li++) begin
          for (int pat = 0; pat < 3; pat++) begin
            for (int kind = 0; kind < 4; kind++) begin
              int s = (si == 0) ? 2 : 5;
              int offs [5] = '{-1, 0, 3, 7, 11};
              int lens [7] = '{0, 1, 2, 3, 5, 8, 9};
              run_fetch(s, s + offs[ei], lens[li], kind, pat, (li + kind + pat) % 3, 1'b0);
            end
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule